// File: doc/BRIEF.md
# Local Interrupt Priority Core

This block sits beside one processor core and decides which maskable interrupt, if any, the core should take next. Interrupt trigger messages arrive as 32-bit words on a valid/ready port. Each word is checked against the local identifier, in physical or logical addressing. Accepted maskable messages set a bit in a 256-entry request vector and record whether that vector is level or edge triggered.

The block continuously finds the highest requested vector and the highest in-service vector. It raises a pending flag when the requested vector outranks the vector now in service, the core has interrupts enabled, and the requested vector's priority class (bits 7:4) is above the class of the task-priority input. A core acknowledge moves that vector from requested to in service. An end-of-interrupt strobe retires the highest in-service vector, which lets lower vectors through. Messages in the unmaskable delivery modes are not queued; a one-cycle flag reports them as unsupported. Messages in reserved modes are dropped and raise a separate error flag.

Back-pressure: `msg_ready` is low during reset and for the first cycle after it. From then on it stays high, so the block takes one message on every cycle in which `msg_valid` is high. The sender may hold a word only while `msg_ready` is low. Once ready is high, no message is ever stalled.

Top module: `lic_prio_core`

## Requirements
- R1: After reset the request, in-service and trigger-mode vectors are all zero, so `intr_pending` is 0, `intr_vector` is 0 and `intr_level` is 0.
- R2: A message is accepted only when bit 19 is 0 and bits 7:0 equal `local_id`, or when bit 19 is 1, `local_id` is below 8 and bit `local_id` of bits 7:0 is set. Any other message changes no output.
- R3: An accepted message whose mode field (bits 18:16) is 0 or 1 sets the request bit of the vector in bits 15:8.
- R4: An accepted message with mode 2, 4, 5 or 7 is not queued. It drives `unsupported` high for exactly the cycle after the transfer.
- R5: An accepted message with mode 3 or 6 is not queued. It drives `reserved_err` high for exactly the cycle after the transfer.
- R6: When a request bit goes from 0 to 1, the vector's trigger mode takes message bit 21 (1 = level, 0 = edge). A message for a vector that is already requested changes nothing. `intr_level` shows the trigger mode of `intr_vector`.
- R7: `intr_vector` is the index of the highest set request bit, or 0 when none is set.
- R8: `intr_pending` is high only when `intr_vector` is greater than the highest in-service index (0 if none), `core_ie` is 1, and `intr_vector[7:4]` is greater than `task_prio[7:4]`.
- R9: `ack` while `intr_pending` is high clears that vector's request bit and sets its in-service bit on the same clock edge.
- R10: `ack` while `intr_pending` is low has no effect.
- R11: `eoi` clears the highest set in-service bit. With no bit in service it has no effect.
- R12: `msg_ready` is 0 in reset and stays 1 from the second clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Trigger message present |
| msg_ready | output | 1 | Block can take a message |
| msg_data | input | 32 | Trigger message word |
| local_id | input | 8 | Identifier of this controller |
| core_ie | input | 1 | Core interrupt-enable flag |
| task_prio | input | 8 | Task priority; bits 7:4 form the class |
| ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End of the highest in-service interrupt |
| intr_pending | output | 1 | A vector may be delivered |
| intr_vector | output | 8 | Highest requested vector |
| intr_level | output | 1 | Trigger mode of intr_vector (1 = level) |
| unsupported | output | 1 | Pulse: unmaskable mode message received |
| reserved_err | output | 1 | Pulse: reserved mode message received |

## Verification
The hardest state to reach is nesting: several vectors in service at once while lower and higher vectors wait in the request vector. In that state an end-of-interrupt must uncover exactly the right vector, and acknowledge, end-of-interrupt and a new message can all land on the same edge. Random stimulus draws vectors from a small pool spread over a few priority classes. It sends acknowledges and end-of-interrupt strobes often, so stacks of in-service vectors build up and unwind. Directed steps first cover task-priority blocking, duplicate messages with the opposite trigger mode, and an acknowledge that arrives with nothing pending.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int VW     = 8;
  localparam int NVEC   = 1 << VW;
  localparam int MSG_W  = 32;
  localparam int ID_W   = 8;
  localparam int CLS_W  = 4;
  localparam int DM_W   = 3;

  localparam int F_DEST_LO = 0;
  localparam int F_VEC_LO  = 8;
  localparam int F_DM_LO   = 16;
  localparam int F_LOGICAL = 19;
  localparam int F_LEVEL   = 20;
  localparam int F_TRIG    = 21;

  typedef enum logic [DM_W-1:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV_A  = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV_B  = 3'd6,
    DM_EXT    = 3'd7
  } dmode_e;

  typedef struct packed {
    logic          hit;
    logic          queue;
    logic          unsup;
    logic          rsv;
    logic          level;
    logic [VW-1:0] vec;
  } msg_dec_t;
endpackage

// File: rtl/lic_msg_decode.sv
module lic_msg_decode
  import lic_pkg::*;
(
  input  logic [MSG_W-1:0] msg,
  input  logic [ID_W-1:0]  local_id,
  output msg_dec_t         dec
);
  localparam int LBITS = ID_W;
  localparam int LSEL  = $clog2(LBITS);

  logic [ID_W-1:0] dest;
  dmode_e          mode;
  logic            logical;
  logic            unused_bits;

  assign dest        = msg[F_DEST_LO +: ID_W];
  assign mode        = dmode_e'(msg[F_DM_LO +: DM_W]);
  assign logical     = msg[F_LOGICAL];
  assign unused_bits = ^{msg[MSG_W-1:F_TRIG+1], msg[F_LEVEL]};

  always_comb begin
    dec.vec   = msg[F_VEC_LO +: VW];
    dec.level = msg[F_TRIG];
    if (logical)
      dec.hit = (local_id < ID_W'(LBITS)) && dest[local_id[LSEL-1:0]];
    else
      dec.hit = (dest == local_id);
    dec.queue = (mode == DM_FIXED) || (mode == DM_LOWEST);
    dec.unsup = (mode == DM_SMI) || (mode == DM_NMI) ||
                (mode == DM_INIT) || (mode == DM_EXT);
    dec.rsv   = (mode == DM_RSV_A) || (mode == DM_RSV_B);
  end
endmodule

// File: rtl/lic_msb_find.sv
module lic_msb_find #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits_in,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++)
      if (bits_in[i]) idx = IW'(i);
  end
endmodule

// File: rtl/lic_prio_core.sv
module lic_prio_core
  import lic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [MSG_W-1:0] msg_data,
  input  logic [ID_W-1:0]  local_id,
  input  logic             core_ie,
  input  logic [VW-1:0]    task_prio,
  input  logic             ack,
  input  logic             eoi,
  output logic             intr_pending,
  output logic [VW-1:0]    intr_vector,
  output logic             intr_level,
  output logic             unsupported,
  output logic             reserved_err
);
  localparam int CLS_LO = VW - CLS_W;

  logic [NVEC-1:0] req_q, svc_q, trg_q;
  logic [NVEC-1:0] req_d, svc_d, trg_d;
  logic [VW-1:0]   top_req, top_svc;
  logic            rdy_q, unsup_q, rsv_q;
  msg_dec_t        dec;
  logic            xfer, do_ack, new_req;

  lic_msg_decode u_dec (.msg(msg_data), .local_id(local_id), .dec(dec));

  for (genvar g = 0; g < 2; g++) begin : g_find
    if (g == 0) begin : g_req
      lic_msb_find #(.W(NVEC)) u_find (.bits_in(req_q), .idx(top_req));
    end else begin : g_svc
      lic_msb_find #(.W(NVEC)) u_find (.bits_in(svc_q), .idx(top_svc));
    end
  end

  assign xfer    = msg_valid && rdy_q && dec.hit;
  assign new_req = xfer && dec.queue && !req_q[dec.vec];

  assign intr_pending = (top_req > top_svc) && core_ie &&
                        (top_req[VW-1:CLS_LO] > task_prio[VW-1:CLS_LO]);
  assign do_ack       = ack && intr_pending;

  always_comb begin
    req_d = req_q;
    trg_d = trg_q;
    svc_d = svc_q;
    if (new_req) begin
      req_d[dec.vec] = 1'b1;
      trg_d[dec.vec] = dec.level;
    end
    if (eoi && (|svc_q)) svc_d[top_svc] = 1'b0;
    if (do_ack) begin
      req_d[top_req] = 1'b0;
      svc_d[top_req] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      svc_q   <= '0;
      trg_q   <= '0;
      rdy_q   <= 1'b0;
      unsup_q <= 1'b0;
      rsv_q   <= 1'b0;
    end else begin
      req_q   <= req_d;
      svc_q   <= svc_d;
      trg_q   <= trg_d;
      rdy_q   <= 1'b1;
      unsup_q <= xfer && dec.unsup;
      rsv_q   <= xfer && dec.rsv;
    end
  end

  assign msg_ready    = rdy_q;
  assign intr_vector  = top_req;
  assign intr_level   = trg_q[top_req];
  assign unsupported  = unsup_q;
  assign reserved_err = rsv_q;
endmodule

// File: rtl/lic_prio_core_chk.sv
module lic_prio_core_chk
  import lic_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic          core_ie,
  input logic [VW-1:0] task_prio,
  input logic          ack,
  input logic          eoi,
  input logic          intr_pending,
  input logic [VW-1:0] intr_vector,
  input logic          unsupported,
  input logic          reserved_err
);
  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    intr_pending |-> core_ie);

  a_r8_class_beats_tpr: assert property (@(posedge clk) disable iff (!rst_n)
    intr_pending |-> (intr_vector[VW-1:VW-CLS_W] > task_prio[VW-1:VW-CLS_W]));

  a_r9_ack_moves_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && intr_pending) |=> (intr_vector != $past(intr_vector)));

  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !intr_pending && !msg_valid && !eoi) |=> $stable(intr_vector));

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(unsupported && reserved_err));

  a_r12_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |=> msg_ready);
endmodule

bind lic_prio_core lic_prio_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .core_ie(core_ie), .task_prio(task_prio), .ack(ack), .eoi(eoi),
  .intr_pending(intr_pending), .intr_vector(intr_vector),
  .unsupported(unsupported), .reserved_err(reserved_err)
);

// File: tb/tb_lic_prio_core.sv
module tb_lic_prio_core;
  logic        clk = 0, rst_n = 0;
  logic        msg_valid = 0, msg_ready;
  logic [31:0] msg_data = 0;
  logic [7:0]  local_id = 8'd3;
  logic        core_ie = 0;
  logic [7:0]  task_prio = 0;
  logic        ack = 0, eoi = 0;
  logic        intr_pending, intr_level, unsupported, reserved_err;
  logic [7:0]  intr_vector;

  int n_chk = 0, n_bad = 0;
  logic [255:0] m_req = '0, m_svc = '0, m_trg = '0;

  always #10 clk = ~clk;

  lic_prio_core dut (.*);

  function automatic int msb(logic [255:0] a);
    int r = 0;
    for (int i = 0; i < 256; i++) if (a[i]) r = i;
    return r;
  endfunction

  function automatic logic [31:0] mk(int vec, int dm, bit logical, bit trig, int dest);
    return {10'd0, trig, 1'b0, logical, dm[2:0], vec[7:0], dest[7:0]};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit mv, logic [31:0] md, bit ak, bit eo, bit ie, logic [7:0] tp);
    int hp, hs, vec, dm;
    bit ep, hit, eu, er;
    msg_valid = mv; msg_data = md; ack = ak; eoi = eo; core_ie = ie; task_prio = tp;
    #1;
    hp = msb(m_req); hs = msb(m_svc);
    ep = (hp > hs) && ie && (hp[7:4] > tp[7:4]);
    chk({tag, " R8 pending"}, intr_pending, ep);
    chk({tag, " R7 vector"}, intr_vector, hp);
    chk({tag, " R6 level"}, intr_level, m_trg[hp]);
    chk({tag, " R12 ready"}, msg_ready, 1);
    vec = md[15:8]; dm = md[18:16];
    if (md[19]) hit = (local_id < 8) && md[local_id[2:0]];
    else        hit = (md[7:0] == local_id);
    hit = hit && mv;
    eu = hit && (dm == 2 || dm == 4 || dm == 5 || dm == 7);
    er = hit && (dm == 3 || dm == 6);
    if (hit && dm <= 1 && !m_req[vec]) begin
      m_req[vec] = 1'b1; m_trg[vec] = md[21];
    end
    if (eo && m_svc != 0) m_svc[hs] = 1'b0;
    if (ak && ep) begin m_svc[hp] = 1'b1; m_req[hp] = 1'b0; end
    @(negedge clk);
    chk({tag, " R4 unsupported"}, unsupported, eu);
    chk({tag, " R5 reserved_err"}, reserved_err, er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r, v, dm, dest;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 pending in reset", intr_pending, 0);
    chk("R1 vector in reset", intr_vector, 0);
    chk("R1 level in reset", intr_level, 0);
    chk("R12 ready low in reset", msg_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 ready after reset", msg_ready, 1);

    cyc("R3 phys fixed", 1, mk(8'h45, 0, 0, 0, 3), 0, 0, 1, 0);
    chk("R3 vector 0x45", intr_vector, 8'h45);
    cyc("R2 logical lowest", 1, mk(8'h80, 1, 1, 1, 8'h08), 0, 0, 1, 0);
    chk("R6 level of 0x80", intr_level, 1);
    cyc("R2 not addressed", 1, mk(8'hF0, 0, 0, 0, 5), 0, 0, 1, 0);
    chk("R2 ignored message", intr_vector, 8'h80);
    cyc("R2 logical miss", 1, mk(8'hF2, 0, 1, 0, 8'hF7), 0, 0, 1, 0);
    cyc("R4 nmi", 1, mk(8'hF1, 4, 0, 0, 3), 0, 0, 1, 0);
    cyc("R5 reserved", 1, mk(8'hF3, 3, 0, 0, 3), 0, 0, 1, 0);
    cyc("R6 duplicate edge", 1, mk(8'h80, 0, 0, 0, 3), 0, 0, 1, 0);
    chk("R6 level kept", intr_level, 1);
    cyc("R8 tpr equal class", 0, 0, 0, 0, 1, 8'h80);
    cyc("R10 ack while blocked", 0, 0, 1, 0, 0, 0);
    chk("R10 vector unchanged", intr_vector, 8'h80);
    cyc("R9 ack", 0, 0, 1, 0, 1, 0);
    chk("R9 next vector", intr_vector, 8'h45);
    cyc("R8 lower than service", 0, 0, 0, 0, 1, 0);
    chk("R8 blocked by service", intr_pending, 0);
    cyc("R11 eoi", 0, 0, 0, 1, 1, 0);
    cyc("R11 after eoi", 0, 0, 0, 0, 1, 0);
    chk("R11 pending restored", intr_pending, 1);
    cyc("R11 eoi empty", 0, 0, 0, 1, 1, 0);

    for (int i = 0; i < 4000; i++) begin
      v = 16 * ($urandom % 6) + 8 + ($urandom % 3);
      dm = ($urandom % 4 == 0) ? $urandom % 8 : $urandom % 2;
      case ($urandom % 4)
        0: dest = 5;
        1: dest = 32'h100 | (1 << ($urandom % 8));
        default: dest = 3;
      endcase
      cyc("RND R3", ($urandom % 3) == 0,
          mk(v, dm, dest[8], $urandom % 2, dest[7:0]),
          ($urandom % 3) == 0, ($urandom % 5) == 0,
          ($urandom % 8) != 0, 8'(16 * ($urandom % 4)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule